// File: doc/BRIEF.md
# SPI Flash Command-Mode Engine

This block sits between a simple request/acknowledge bus port and the four-wire pins of one SPI flash device. It holds one 32-bit control word that picks the operating mode, the read opcode, a dummy-byte count, an I/O width and a clock-divider code. The bus port reaches either this control word or the flash window, as chosen by a select input.

In the two command-read modes, a read of the window makes the engine frame a whole flash read. It lowers chip select, shifts out the opcode, then the offset as three or four address bytes, then any dummy bytes. It then shifts in the requested number of data bytes, releases chip select and acknowledges the bus. In user mode, software frames the transaction itself. A stop bit in the control word drives chip select, and each window write or read moves exactly one byte on the wire before the bus is acknowledged.

The serial clock is derived from the bus clock by a divisor of 1 to 16, selected through an interleaved code. Data reads can use two data lines, with the address and dummy bytes either on one line or on two.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, bus_ack is 0 and the control word reads back as CTRL_INIT (default 0).
- R2: Each access is acknowledged by a bus_ack pulse exactly one cycle wide. A control access (bus_ctrl=1) returns the control word in bus_rdata, and a control write replaces the word with bus_wdata; the new value is read back in full.
- R3: With mode field ctrl[1:0]=0, a window read frames one transfer with chip select low throughout. The transfer carries the opcode ctrl[23:16], then 3 address bytes (most significant first), then bus_nbytes+1 data bytes. Data byte k lands in bus_rdata[8k+7:8k]. Chip select rises after the last data byte. The dummy field and the I/O-width bits have no effect in this mode.
- R4: When addr4_en is 1 at the start of a command read, 4 address bytes are sent instead of 3.
- R5: With mode 1, the dummy count is {ctrl[14], ctrl[7:6]}, and that many 0xFF bytes follow the address.
- R6: The divider code ctrl[11:8] picks the divisor by position in the list 15,7,14,6,13,5,12,4,11,3,10,2,9,1,8,0, which stands for divisors 1 to 16. The SCK period is that many clk cycles, with the high phase lasting floor(divisor/2) cycles. Divisor 1 runs at divisor 2.
- R7: Transfers are SPI mode 0 and most significant bit first. Outputs change while SCK is low, and inputs are sampled on the SCK rising edge. In single-bit transfers spi_io[0] is the output line and spi_io[1] the input line.
- R8: With mode 1 and ctrl[31:28]=0b0010, data bytes take 4 clocks with both lines input (spi_io_oe=00), and spi_io[1] carries the higher bit. Opcode, address and dummy bytes stay single-bit.
- R9: With mode 1 and ctrl[31:28]=0b0011, address and dummy bytes are also sent two bits per clock with spi_io_oe=11, and spi_io[1] carries the higher bit. The opcode stays single-bit.
- R10: Any other value of ctrl[31:28], including every value with bit 30 set, gives single-bit transfers.
- R11: In user mode (mode 3), spi_cs_n follows stop bit ctrl[2]. A window write shifts out bus_wdata[7:0] in 8 clocks. A window read shifts out 0xFF, returns the captured byte in bus_rdata[7:0] and leaves chip select as it was.
- R12: A window access with the stop bit set, any window access in mode 2, and a window write in mode 0 or 1 are acknowledged with bus_rdata=0, no SCK edge and no chip-select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the source of SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctrl | input | 1 | 1 = control word, 0 = flash window |
| bus_addr | input | ADDR_W | Flash offset of a window read |
| bus_nbytes | input | 2 | Data bytes minus one for a command read |
| bus_wdata | input | 32 | Control value, or window byte in [7:0] |
| bus_rdata | output | 32 | Read result, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion pulse |
| addr4_en | input | 1 | Selects 4-byte addressing |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_o | output | 2 | Line drive values |
| spi_io_oe | output | 2 | Line drive enables |
| spi_io_i | input | 2 | Line input values |

## Verification
The bench builds the engine with ADDR_W=32 and CTRL_INIT=0. The full 32-bit offset therefore reaches the wire in 4-byte mode, and the reset divider is the slowest one, divide by 16. A slave model in the bench records the line values and enables at every SCK rise and answers from a per-clock pattern. This lets one run compare whole frames across single, dual-data and dual-address layouts, dummy counts up to 5, and divisor codes for 16, 7, 6 and the clamped divide-by-1.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] CTRL_INIT = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic              bus_ctrl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_nbytes,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  input  logic              addr4_en,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic [1:0]        spi_io_o,
  output logic [1:0]        spi_io_oe,
  input  logic [1:0]        spi_io_i
);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_ACK} st_t;
  typedef enum logic [1:0] {P_OP, P_ADDR, P_DUM, P_DATA} ph_t;

  st_t         st;
  ph_t         ph;
  logic [31:0] ctrl_q, rdata_q, addr_sh;
  logic        cmd_q, cs_act, a4_q, sck_q;
  logic [4:0]  div_cnt;
  logic [2:0]  clk_done, cnt;
  logic [1:0]  idx, nb_q;
  logic [7:0]  tx_sh, rx_sh;

  wire [1:0]  mode   = ctrl_q[1:0];
  wire        stop   = ctrl_q[2];
  wire [7:0]  opcode = ctrl_q[23:16];
  wire [2:0]  dummy  = {ctrl_q[14], ctrl_q[7:6]};
  wire [3:0]  dcode  = ctrl_q[11:8];
  wire [3:0]  iom    = ctrl_q[31:28];
  wire        fast   = (mode == 2'd1);
  wire        dual_d = fast && (iom == 4'b0010 || iom == 4'b0011);
  wire        dual_a = fast && (iom == 4'b0011);
  wire [31:0] addr32 = 32'(bus_addr);

  wire [4:0] divisor = dcode[3] ? {1'b0, ~dcode[2:0], 1'b1}
                                : {1'b0, ~dcode[2:0], 1'b0} + 5'd2;
  wire [4:0] eff     = (divisor < 5'd2) ? 5'd2 : divisor;
  wire [4:0] lo_len  = (eff + 5'd1) >> 1;
  wire [4:0] hi_len  = eff >> 1;

  wire cur_dual = (st == S_SHIFT) && cmd_q &&
                  ((ph == P_DATA && dual_d) || ((ph == P_ADDR || ph == P_DUM) && dual_a));
  wire [2:0] last_clk = cur_dual ? 3'd3 : 3'd7;

  assign spi_sck   = sck_q;
  assign spi_cs_n  = stop | ((mode == 2'd3) ? 1'b0 : !cs_act);
  assign spi_io_o  = cur_dual ? tx_sh[7:6] : {1'b0, tx_sh[7]};
  assign spi_io_oe = !cur_dual ? 2'b01 : ((ph == P_DATA) ? 2'b00 : 2'b11);
  assign bus_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= P_OP;  ctrl_q <= CTRL_INIT;  rdata_q <= '0;
      bus_ack <= 1'b0;  cmd_q <= 1'b0;  cs_act <= 1'b0;  a4_q <= 1'b0;
      sck_q <= 1'b0;  div_cnt <= '0;  clk_done <= '0;  cnt <= '0;
      idx <= '0;  nb_q <= '0;  tx_sh <= 8'hFF;  rx_sh <= '0;  addr_sh <= '0;
    end else begin
      bus_ack <= 1'b0;
      unique case (st)
        S_IDLE: if (bus_valid) begin
          sck_q <= 1'b0;  div_cnt <= '0;  clk_done <= '0;  idx <= '0;  rdata_q <= '0;
          if (bus_ctrl) begin
            if (bus_we) ctrl_q <= bus_wdata;
            rdata_q <= ctrl_q;
            st      <= S_ACK;
            bus_ack <= 1'b1;
          end else if (stop || mode == 2'd2 || (mode != 2'd3 && bus_we)) begin
            st      <= S_ACK;
            bus_ack <= 1'b1;
          end else if (mode == 2'd3) begin
            cmd_q <= 1'b0;  ph <= P_DATA;  cnt <= '0;
            tx_sh <= bus_we ? bus_wdata[7:0] : 8'hFF;
            st    <= S_SHIFT;
          end else begin
            cmd_q   <= 1'b1;  cs_act <= 1'b1;  ph <= P_OP;  tx_sh <= opcode;
            a4_q    <= addr4_en;  nb_q <= bus_nbytes;
            addr_sh <= addr4_en ? addr32 : {addr32[23:0], 8'h00};
            st      <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!sck_q) begin
            if (div_cnt == lo_len - 5'd1) begin
              sck_q   <= 1'b1;
              div_cnt <= '0;
              rx_sh   <= cur_dual ? {rx_sh[5:0], spi_io_i[1], spi_io_i[0]}
                                  : {rx_sh[6:0], spi_io_i[1]};
            end else div_cnt <= div_cnt + 5'd1;
          end else if (div_cnt != hi_len - 5'd1) begin
            div_cnt <= div_cnt + 5'd1;
          end else begin
            sck_q   <= 1'b0;
            div_cnt <= '0;
            if (clk_done != last_clk) begin
              clk_done <= clk_done + 3'd1;
              tx_sh    <= cur_dual ? {tx_sh[5:0], 2'b11} : {tx_sh[6:0], 1'b1};
            end else begin
              clk_done <= '0;
              unique case (ph)
                P_OP: begin
                  ph      <= P_ADDR;
                  cnt     <= a4_q ? 3'd3 : 3'd2;
                  tx_sh   <= addr_sh[31:24];
                  addr_sh <= {addr_sh[23:0], 8'h00};
                end
                P_ADDR: begin
                  if (cnt != 3'd0) begin
                    cnt     <= cnt - 3'd1;
                    tx_sh   <= addr_sh[31:24];
                    addr_sh <= {addr_sh[23:0], 8'h00};
                  end else if (fast && dummy != 3'd0) begin
                    ph <= P_DUM;  cnt <= dummy - 3'd1;  tx_sh <= 8'hFF;
                  end else begin
                    ph <= P_DATA;  cnt <= {1'b0, nb_q};  tx_sh <= 8'hFF;
                  end
                end
                P_DUM: begin
                  tx_sh <= 8'hFF;
                  if (cnt != 3'd0) cnt <= cnt - 3'd1;
                  else begin
                    ph <= P_DATA;  cnt <= {1'b0, nb_q};
                  end
                end
                P_DATA: begin
                  rdata_q[{idx, 3'b000} +: 8] <= rx_sh;
                  idx   <= idx + 2'd1;
                  tx_sh <= 8'hFF;
                  if (cmd_q && cnt != 3'd0) cnt <= cnt - 3'd1;
                  else begin
                    cs_act  <= 1'b0;
                    st      <= S_ACK;
                    bus_ack <= 1'b1;
                  end
                end
              endcase
            end
          end
        end
        S_ACK: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) bus_ack |=> !bus_ack); // R2
  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) spi_sck |-> !spi_cs_n); // R3
  AST_CS_HELD_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n) (st == S_SHIFT && cmd_q) |-> !spi_cs_n); // R3
  AST_DUAL_RX_MODE: assert property (@(posedge clk) disable iff (!rst_n) (spi_io_oe == 2'b00) |-> (ctrl_q[1:0] == 2'd1 && ctrl_q[31:29] == 3'b001)); // R8
  AST_QUAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[30] |-> (spi_io_oe == 2'b01)); // R10
  AST_STOP_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[2] && st == S_IDLE) |=> !spi_sck); // R12

endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0, bus_ctrl = 1'b0, addr4_en = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [1:0]  bus_nbytes = '0;
  logic [31:0] bus_rdata;
  logic bus_ack, spi_sck, spi_cs_n;
  logic [1:0] spi_io_o, spi_io_oe;
  logic [1:0] spi_io_i = 2'b00;

  spi_cmd_engine #(.ADDR_W(32), .CTRL_INIT(32'h0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we), .bus_ctrl(bus_ctrl),
    .bus_addr(bus_addr), .bus_nbytes(bus_nbytes), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .addr4_en(addr4_en), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [1:0] exp_out [256];
  logic [1:0] exp_oe  [256];
  bit         exp_chk [256];
  logic [1:0] pat_in  [256];
  logic [1:0] rec_out [256];
  logic [1:0] rec_oe  [256];
  logic       rec_cs  [256];
  realtime    rec_t   [256];
  realtime    fall_t  [256];
  int n_exp = 0, rise_cnt = 0, cs_falls = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge spi_sck) begin
    if (rise_cnt < 256) begin
      rec_out[rise_cnt] = spi_io_o;
      rec_oe[rise_cnt]  = spi_io_oe;
      rec_cs[rise_cnt]  = spi_cs_n;
      rec_t[rise_cnt]   = $realtime;
    end
    rise_cnt++;
  end
  always @(negedge spi_sck) begin
    if (rise_cnt > 0 && rise_cnt <= 256) fall_t[rise_cnt-1] = $realtime;
    spi_io_i = (rise_cnt < 256) ? pat_in[rise_cnt] : 2'b00;
  end
  always @(negedge spi_cs_n) cs_falls++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] iom, input logic [7:0] op, input logic [2:0] d,
                                     input logic [3:0] code, input logic stp, input logic [1:0] md);
    return {iom, 4'b0, op, 1'b0, d[2], 2'b0, code, d[1:0], 3'b0, stp, md};
  endfunction

  function automatic int div_of(input logic [3:0] code);
    int codes [16] = '{15, 7, 14, 6, 13, 5, 12, 4, 11, 3, 10, 2, 9, 1, 8, 0};
    for (int i = 0; i < 16; i++) if (codes[i] == int'(code)) return i + 1;
    return 0;
  endfunction

  task automatic clr_exp();
    n_exp = 0;
    for (int i = 0; i < 256; i++) pat_in[i] = 2'b00;
  endtask

  task automatic add_out(input logic [7:0] b, input bit dual);
    if (!dual) for (int i = 0; i < 8; i++) begin
      exp_out[n_exp] = {1'b0, b[7-i]}; exp_oe[n_exp] = 2'b01; exp_chk[n_exp] = 1; n_exp++;
    end else for (int i = 0; i < 4; i++) begin
      exp_out[n_exp] = {b[7-2*i], b[6-2*i]}; exp_oe[n_exp] = 2'b11; exp_chk[n_exp] = 1; n_exp++;
    end
  endtask

  task automatic add_in(input logic [7:0] b, input bit dual);
    if (!dual) for (int i = 0; i < 8; i++) begin
      pat_in[n_exp] = {b[7-i], 1'b0}; exp_oe[n_exp] = 2'b01; exp_chk[n_exp] = 0; n_exp++;
    end else for (int i = 0; i < 4; i++) begin
      pat_in[n_exp] = {b[7-2*i], b[6-2*i]}; exp_oe[n_exp] = 2'b00; exp_chk[n_exp] = 0; n_exp++;
    end
  endtask

  task automatic reset_mon();
    rise_cnt = 0; cs_falls = 0; spi_io_i = pat_in[0];
  endtask

  task automatic bus_xfer(input logic c, input logic we, input logic [31:0] a, input logic [1:0] nb,
                          input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1; bus_ctrl = c; bus_we = we; bus_addr = a; bus_nbytes = nb; bus_wdata = wd;
    do @(negedge clk); while (!bus_ack);
    rd = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    logic [31:0] d;
    bus_xfer(1, 1, 32'h0, 2'd0, v, d);
  endtask

  task automatic check_stream(input string tag);
    int bad = 0;
    for (int k = 0; k < n_exp && k < 256; k++) begin
      if (rec_oe[k] !== exp_oe[k] || rec_cs[k] !== 1'b0) bad++;
      else if (exp_chk[k] && (exp_oe[k] == 2'b11 ? rec_out[k] !== exp_out[k]
                                                  : rec_out[k][0] !== exp_out[k][0])) bad++;
    end
    chk(rise_cnt == n_exp, {tag, " clock count"}, rise_cnt, n_exp);
    chk(bad == 0, {tag, " line pattern mismatches"}, bad, 0);
  endtask

  task automatic cmd_read(input string tag, input logic [31:0] cv, input logic a4, input logic [31:0] addr,
                          input logic [1:0] nb, input logic [31:0] data, input bit da, input bit dd,
                          input int ndum);
    logic [31:0] rd, rd_exp;
    int na;
    wr_ctrl(cv);
    addr4_en = a4;
    na = a4 ? 4 : 3;
    clr_exp();
    add_out(cv[23:16], 0);
    for (int j = 0; j < na; j++) add_out(8'((addr >> (8 * (na - 1 - j))) & 32'hFF), da);
    for (int j = 0; j < ndum; j++) add_out(8'hFF, da);
    rd_exp = '0;
    for (int k = 0; k <= int'(nb); k++) begin
      add_in(data[8*k +: 8], dd);
      rd_exp[8*k +: 8] = data[8*k +: 8];
    end
    reset_mon();
    bus_xfer(0, 0, addr, nb, 32'h0, rd);
    check_stream(tag);
    chk(rd == rd_exp, {tag, " read data"}, rd, rd_exp);
    chk(spi_cs_n == 1'b1, {tag, " chip select released"}, spi_cs_n, 1);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    chk(spi_cs_n == 1 && spi_sck == 0 && bus_ack == 0, "R1 reset pins", {spi_cs_n, spi_sck, bus_ack}, 3'b100);
    bus_xfer(1, 0, 32'h0, 2'd0, 32'h0, rd);
    chk(rd == 32'h0, "R1 reset control word", rd, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] rd;
    wr_ctrl(32'h9A5B_3C41);
    bus_xfer(1, 0, 32'h0, 2'd0, 32'h0, rd);
    chk(rd == 32'h9A5B_3C41, "R2 control readback", rd, 32'h9A5B_3C41);
    @(negedge clk);
    chk(bus_ack == 0, "R2 ack is one cycle", bus_ack, 0);
  endtask

  task automatic t_norm();
    // R3 R7: dummy field and dual bits set but mode 0 ignores them
    cmd_read("R3 normal read", mk(4'b0011, 8'h03, 3'd5, 4'd15, 0, 2'd0), 0, 32'h0012_3456, 2'd3,
             32'hEFBE_ADDE, 0, 0, 0);
  endtask

  task automatic t_addr4();
    cmd_read("R4 four-byte address", mk(4'b0000, 8'h13, 3'd0, 4'd7, 0, 2'd0), 1, 32'h89AB_CDEF, 2'd0,
             32'h0000_00A7, 0, 0, 0);
  endtask

  task automatic t_fast();
    cmd_read("R5 fast read five dummies", mk(4'b0000, 8'h0B, 3'd5, 4'd7, 0, 2'd1), 0, 32'h0000_0F0F, 2'd1,
             32'h0000_3C5A, 0, 0, 5);
  endtask

  task automatic t_div();
    logic [3:0] codes [4] = '{4'd0, 4'd12, 4'd5, 4'd15};
    for (int i = 0; i < 4; i++) begin
      int e;
      realtime p, h;
      e = div_of(codes[i]);
      if (e < 2) e = 2;
      cmd_read("R6 divider frame", mk(4'b0000, 8'h03, 3'd0, codes[i], 0, 2'd0), 0, 32'h0000_0100, 2'd0,
               32'h0000_0081, 0, 0, 0);
      p = rec_t[1] - rec_t[0];
      h = fall_t[0] - rec_t[0];
      chk(p > e * 8.0 - 0.5 && p < e * 8.0 + 0.5, "R6 sck period ns", $rtoi(p), e * 8);
      chk(h > (e / 2) * 8.0 - 0.5 && h < (e / 2) * 8.0 + 0.5, "R6 sck high ns", $rtoi(h), (e / 2) * 8);
    end
  endtask

  task automatic t_dual_data();
    cmd_read("R8 dual data", mk(4'b0010, 8'h3B, 3'd1, 4'd7, 0, 2'd1), 0, 32'h0003_0201, 2'd1,
             32'h0000_B46D, 0, 1, 1);
  endtask

  task automatic t_dual_addr();
    cmd_read("R9 dual address and data", mk(4'b0011, 8'hBB, 3'd2, 4'd6, 0, 2'd1), 0, 32'h00C1_E29D, 2'd2,
             32'h0071_8E4B, 1, 1, 2);
  endtask

  task automatic t_quad();
    cmd_read("R10 quad data code", mk(4'b0100, 8'h6B, 3'd1, 4'd7, 0, 2'd1), 0, 32'h0000_2222, 2'd0,
             32'h0000_0096, 0, 0, 1);
    cmd_read("R10 quad addr code", mk(4'b0111, 8'hEB, 3'd1, 4'd7, 0, 2'd1), 0, 32'h0000_4444, 2'd0,
             32'h0000_0069, 0, 0, 1);
  endtask

  task automatic t_user();
    logic [31:0] rd;
    wr_ctrl(mk(4'b0000, 8'h00, 3'd0, 4'd7, 1, 2'd3));
    chk(spi_cs_n == 1, "R11 stop bit holds cs high", spi_cs_n, 1);
    wr_ctrl(mk(4'b0000, 8'h00, 3'd0, 4'd7, 0, 2'd3));
    chk(spi_cs_n == 0, "R11 clearing stop selects", spi_cs_n, 0);
    clr_exp(); add_out(8'h5A, 0); reset_mon();
    bus_xfer(0, 1, 32'h0, 2'd0, 32'h0000_005A, rd);
    check_stream("R11 user write byte");
    clr_exp(); add_in(8'hC3, 0); reset_mon();
    bus_xfer(0, 0, 32'h0, 2'd0, 32'h0, rd);
    check_stream("R11 user read byte");
    chk(rd == 32'h0000_00C3, "R11 user read data", rd, 32'hC3);
    chk(spi_cs_n == 0 && cs_falls == 0, "R11 cs stays low between bytes", spi_cs_n, 0);
    wr_ctrl(mk(4'b0000, 8'h00, 3'd0, 4'd7, 1, 2'd3));
    chk(spi_cs_n == 1, "R11 setting stop deselects", spi_cs_n, 1);
  endtask

  task automatic t_ignored();
    logic [31:0] rd;
    wr_ctrl(mk(4'b0000, 8'h03, 3'd0, 4'd7, 0, 2'd2));
    clr_exp(); reset_mon();
    bus_xfer(0, 0, 32'h10, 2'd3, 32'h0, rd);
    chk(rd == 0 && rise_cnt == 0 && cs_falls == 0 && spi_cs_n == 1, "R12 mode 2 window read",
        {rd[7:0], 8'(rise_cnt), 8'(cs_falls)}, 0);
    wr_ctrl(mk(4'b0000, 8'h03, 3'd0, 4'd7, 1, 2'd0));
    reset_mon();
    bus_xfer(0, 0, 32'h10, 2'd0, 32'h0, rd);
    chk(rd == 0 && rise_cnt == 0 && cs_falls == 0 && spi_cs_n == 1, "R12 stop bit blocks read",
        {rd[7:0], 8'(rise_cnt), 8'(cs_falls)}, 0);
    wr_ctrl(mk(4'b0000, 8'h03, 3'd0, 4'd7, 0, 2'd1));
    reset_mon();
    bus_xfer(0, 1, 32'h10, 2'd0, 32'h0000_00AA, rd);
    chk(rd == 0 && rise_cnt == 0 && cs_falls == 0 && spi_cs_n == 1, "R12 window write in read mode",
        {rd[7:0], 8'(rise_cnt), 8'(cs_falls)}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pat_in[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_norm();
    t_addr4();
    t_fast();
    t_div();
    t_dual_data();
    t_dual_addr();
    t_quad();
    t_user();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule